// File: doc/BRIEF.md
# Serial Transmitter with Half-Duplex Bus Turnaround

This block is the transmit half of an asynchronous serial port that drives a half-duplex differential bus. Bytes written through a simple strobe-and-data port go into a transmit queue. A shift register then sends each byte as a ten-bit character, one bit per baud tick. The queue holds up to sixteen bytes when enabled. When it is disabled it acts as a single holding register.

Two status flags tell software how far the data has got. The holding-empty flag shows that no byte is waiting to be transmitted. The transmitter-empty flag shows that the shift register has also finished, so the last stop bit is off the line. The block also drives the bus driver-enable itself. It raises the enable before the first start bit goes out and drops it on the baud tick that ends the final stop bit. The turnaround therefore never depends on how long the packet was. An interrupt request pulses when the holding-empty flag rises, and software can use it to refill the queue.

Top module: `serial_tx_rs485`

## Requirements
- R1: After reset, `txd` is 1, `drv_en` is 0, `irq` is 0 and `status` reads 8'h60. Status bits 7, 4, 3, 2 and 0 always read 0.
- R2: Each character is one start bit (0), then eight data bits with the least significant bit first, then one stop bit (1). Once the start bit is on the line, `txd` changes only in the cycle after a clock edge at which `baud_tick` was 1. The line idles at 1.
- R3: Bytes go out in the order they were accepted. When more data is queued, the next start bit follows the tick that ends the previous stop bit, with no idle bit in between.
- R4: `status[5]` (holding empty) is 1 exactly when no accepted byte is waiting. In queue mode it stays 0 until the last queued byte has moved into the shift register.
- R5: With `fifo_en` = 0 the block holds one byte. A write while that byte is still waiting is dropped. `status[5]` returns to 1 in the cycle after the byte moves into the shift register.
- R6: `status[6]` (transmitter empty) is 1 only when nothing is waiting and the shift register is idle. It rises in the cycle after the tick that ends the last stop bit, and while it is 1 `txd` is 1.
- R7: `drv_en` rises in the cycle after the first accepted write from idle, one cycle before the start bit appears. For a packet of L bytes it falls exactly 10·L ticks after the first start bit appears, at the same edge where `status[6]` rises.
- R8: In queue mode the queue holds 16 bytes. A write while the queue is full is dropped and sets `status[1]`. `status[1]` stays set until the queue is flushed.
- R9: `fifo_clr` discards all waiting bytes and clears `status[1]`, and a write in the same cycle is ignored. The character already in the shift register is still completed.
- R10: `irq` is a one-cycle pulse in the first cycle that `status[5]` reads 1 after reading 0.
- R11: Any change of `fifo_en` flushes the queue in the same way as `fifo_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| fifo_en | input | 1 | 1: 16-entry queue, 0: single holding register |
| fifo_clr | input | 1 | Flush waiting bytes and clear overflow |
| baud_tick | input | 1 | One pulse per bit time |
| txd | output | 1 | Serial line, idles high |
| drv_en | output | 1 | Bus driver enable |
| status | output | 8 | Line status: bit 6 transmitter empty, bit 5 holding empty, bit 1 overflow |
| irq | output | 1 | Pulse when holding-empty rises |

## Verification
A write at one edge is visible on the next cycle: the holding-empty flag drops and `drv_en` rises. The start bit appears one cycle after that, and from then on each bit moves only after an edge that saw a tick. The bench drives inputs and samples outputs on the falling clock edge. It keeps a per-cycle software decoder of `txd` and counts the ticks since the first start bit. Each flag transition is then compared against an arithmetic target: holding-empty at 10·(L−1) ticks, and driver release with transmitter-empty at 10·L ticks. Single-cycle effects such as the write after a flush, the dropped overflow byte and the interrupt pulse are checked on the sample that follows the edge that caused them.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int DATA_W   = 8;
    localparam int FRAME_W  = DATA_W + 2;
    localparam int STAT_W   = 8;
    localparam int OVF_BIT  = 1;
    localparam int THRE_BIT = 5;
    localparam int TEMT_BIT = 6;

    typedef logic [DATA_W-1:0]  byte_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [STAT_W-1:0]  stat_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic line_idle;
        logic hold_empty;
        logic overflow;
    } flags_t;

    // stop bit at the top, start bit at the bottom: shifted out LSB first
    function automatic frame_t make_frame(input byte_t d);
        return {1'b1, d, 1'b0};
    endfunction

    function automatic stat_t pack_status(input flags_t f);
        stat_t s;
        s           = '0;
        s[TEMT_BIT] = f.line_idle;
        s[THRE_BIT] = f.hold_empty;
        s[OVF_BIT]  = f.overflow;
        return s;
    endfunction

endpackage

// File: rtl/stx_queue.sv
module stx_queue
    import stx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fifo_en,
    input  logic  clr,
    input  logic  push,
    input  byte_t push_data,
    input  logic  pop,
    output byte_t head,
    output logic  empty,
    output logic  accepted,
    output logic  ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    byte_t          mem [DEPTH];
    logic [AW-1:0]  wptr;
    logic [AW-1:0]  rptr;
    logic [CW-1:0]  count;
    logic [CW-1:0]  cap;
    logic           en_q;
    logic           flush;
    logic           full;
    logic           pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // queue mode uses every slot, holding-register mode only one
    assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
    assign full     = (count >= cap);
    assign empty    = (count == '0);
    assign flush    = clr | (fifo_en != en_q);
    assign accepted = push & ~full & ~flush;
    assign pop_ok   = pop & ~empty;
    assign head     = mem[rptr];

    always_ff @(posedge clk) begin
        if (accepted) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            en_q  <= fifo_en;
            ovf   <= 1'b0;
        end else begin
            if (accepted) begin
                wptr <= bump(wptr);
            end
            if (pop_ok) begin
                rptr <= bump(rptr);
            end
            case ({accepted, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) begin
                ovf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
    import stx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  baud_tick,
    input  logic  avail,
    input  byte_t data,
    output logic  take,
    output logic  txd,
    output logic  sending,
    output logic  frame_done
);

    localparam int CNT_W = $clog2(FRAME_W + 1);

    tx_state_e         state;
    frame_t            shreg;
    logic [CNT_W-1:0]  left;

    assign sending    = (state == TX_SEND);
    // the tick that closes the final bit of the current character
    assign frame_done = sending && baud_tick && (left == CNT_W'(1));
    // load from idle, or back to back on the closing tick
    assign take       = avail && (!sending || frame_done);
    assign txd        = sending ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            shreg <= '1;
            left  <= '0;
        end else if (take) begin
            state <= TX_SEND;
            shreg <= make_frame(data);
            left  <= CNT_W'(FRAME_W);
        end else if (sending && baud_tick) begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - 1'b1;
            if (frame_done) begin
                state <= TX_IDLE;
            end
        end
    end

endmodule

// File: rtl/stx_line_ctl.sv
module stx_line_ctl
    import stx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_accept,
    input  logic  frame_done,
    input  logic  take,
    input  logic  q_empty,
    input  logic  sending,
    input  logic  ovf,
    output logic  drv_en,
    output stat_t status,
    output logic  irq
);

    flags_t flags;
    logic   thre_d;

    assign flags.hold_empty = q_empty;
    assign flags.line_idle  = q_empty & ~sending;
    assign flags.overflow   = ovf;
    assign status           = pack_status(flags);
    assign irq              = flags.hold_empty & ~thre_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_en <= 1'b0;
            thre_d <= 1'b1;
        end else begin
            thre_d <= flags.hold_empty;
            if (wr_accept) begin
                drv_en <= 1'b1;
            end else if (frame_done && !take) begin
                drv_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/serial_tx_rs485.sv
module serial_tx_rs485
    import stx_pkg::*;
#(
    parameter int QUEUE_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       fifo_en,
    input  logic       fifo_clr,
    input  logic       baud_tick,
    output logic       txd,
    output logic       drv_en,
    output logic [7:0] status,
    output logic       irq
);

    byte_t q_head;
    logic  q_empty;
    logic  q_accept;
    logic  q_ovf;
    logic  take;
    logic  sending;
    logic  frame_done;
    stat_t stat_w;

    stx_queue #(
        .DEPTH (QUEUE_DEPTH)
    ) queue_i (
        .clk       (clk),
        .rst       (rst),
        .fifo_en   (fifo_en),
        .clr       (fifo_clr),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (take),
        .head      (q_head),
        .empty     (q_empty),
        .accepted  (q_accept),
        .ovf       (q_ovf)
    );

    stx_shifter shifter_i (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .avail      (~q_empty),
        .data       (q_head),
        .take       (take),
        .txd        (txd),
        .sending    (sending),
        .frame_done (frame_done)
    );

    stx_line_ctl line_ctl_i (
        .clk        (clk),
        .rst        (rst),
        .wr_accept  (q_accept),
        .frame_done (frame_done),
        .take       (take),
        .q_empty    (q_empty),
        .sending    (sending),
        .ovf        (q_ovf),
        .drv_en     (drv_en),
        .status     (stat_w),
        .irq        (irq)
    );

    assign status = stat_w;

endmodule

// File: rtl/serial_tx_rs485_chk.sv
module serial_tx_rs485_chk (
    input logic       clk,
    input logic       rst,
    input logic       fifo_en,
    input logic       fifo_clr,
    input logic       baud_tick,
    input logic       txd,
    input logic       drv_en,
    input logic [7:0] status,
    input logic       irq
);

    AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status & 8'h9D) == 8'h00); // R1

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        status[6] |-> txd); // R6

    AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (rst)
        status[6] |-> status[5]); // R6

    AST_DRV_OPPOSES_TEMT: assert property (@(posedge clk) disable iff (rst)
        drv_en != status[6]); // R7

    AST_START_AFTER_DRV: assert property (@(posedge clk) disable iff (rst)
        $fell(txd) |-> $past(drv_en)); // R7

    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_en) |-> ($past(baud_tick) && txd)); // R7

    AST_IRQ_ON_THRE_EDGE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status[5] && !$past(status[5]))); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status[1] && !fifo_clr && (fifo_en == $past(fifo_en))) |=> status[1]); // R8

endmodule

bind serial_tx_rs485 serial_tx_rs485_chk chk_i (.*);

// File: tb/serial_tx_rs485_tb_top.sv
`timescale 1ns/1ps
module serial_tx_rs485_tb_top;

    localparam int DIV     = 3;
    localparam int MAXWAIT = 2000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_en = 1'b1;
    logic       fifo_clr = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd;
    logic       drv_en;
    logic [7:0] status;
    logic       irq;

    int n_checks = 0;
    int n_err    = 0;

    // next inputs, applied at the falling edge inside cycle()
    logic       n_wr = 1'b0;
    logic [7:0] n_data = 8'h00;
    logic       n_clr = 1'b0;
    logic       n_fen = 1'b1;

    // samples
    logic       s_txd, s_drv, s_irq;
    logic [7:0] s_st;
    logic       prev_tick = 1'b0;
    logic       last_txd = 1'b1;
    int         cyc_cnt = 0;

    // software line decoder
    logic       dec_busy = 1'b0;
    int         dec_idx = 0;
    logic [7:0] dec_byte = 8'h00;
    logic [7:0] exp_q [64];
    int         exp_wr = 0;
    int         exp_rd = 0;

    // packet timing measurements
    logic       pk_armed = 1'b0;
    logic       pk_started = 1'b0;
    int         pk_ticks = 0;
    int         thre_tick = -1;
    int         fall_tick = -1;

    always #10 clk = ~clk;

    serial_tx_rs485 dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .fifo_en   (fifo_en),
        .fifo_clr  (fifo_clr),
        .baud_tick (baud_tick),
        .txd       (txd),
        .drv_en    (drv_en),
        .status    (status),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int l, input int i);
        return 8'((l * 37 + i * 91 + 5) % 256);
    endfunction

    task automatic push_exp(input logic [7:0] d);
        exp_q[exp_wr % 64] = d;
        exp_wr++;
    endtask

    task automatic cycle();
        @(negedge clk);
        s_txd = txd;
        s_drv = drv_en;
        s_st  = status;
        s_irq = irq;
        if (pk_started && prev_tick) pk_ticks++;
        if (dec_busy) begin
            if (prev_tick) begin
                dec_idx++;
                if (dec_idx <= 8) begin
                    dec_byte[dec_idx-1] = s_txd;
                end else if (dec_idx == 9) begin
                    check(s_txd == 1'b1, "R2", "stop bit level", s_txd, 1);
                end else begin
                    dec_busy = 1'b0;
                    if (exp_rd == exp_wr) begin
                        check(1'b0, "R3", "unexpected byte on line", dec_byte, -1);
                    end else begin
                        check(dec_byte == exp_q[exp_rd % 64], "R3", "byte order/value",
                              dec_byte, exp_q[exp_rd % 64]);
                        exp_rd++;
                    end
                end
            end else if (s_txd != last_txd) begin
                check(1'b0, "R2", "line moved without a tick", s_txd, last_txd);
            end
        end
        if (!dec_busy && s_txd == 1'b0) begin
            dec_busy = 1'b1;
            dec_idx  = 0;
            if (pk_armed && !pk_started) begin
                pk_started = 1'b1;
                pk_ticks   = 0;
            end
        end
        if (pk_started && thre_tick < 0 && s_st[5]) begin
            thre_tick = pk_ticks;
            check(s_irq == 1'b1, "R10", "irq on holding-empty rise", s_irq, 1);
        end
        if (pk_started && fall_tick < 0 && !s_drv) begin
            fall_tick = pk_ticks;
            check(s_st[6] == 1'b1 && s_txd == 1'b1, "R6", "temt/line at release",
                  {s_st[6], s_txd}, 3);
        end
        last_txd  = s_txd;
        wr_en     = n_wr;
        wr_data   = n_data;
        fifo_clr  = n_clr;
        fifo_en   = n_fen;
        baud_tick = ((cyc_cnt % DIV) == DIV - 1);
        prev_tick = baud_tick;
        cyc_cnt++;
        n_wr  = 1'b0;
        n_clr = 1'b0;
    endtask

    task automatic wait_release();
        for (int k = 0; k < MAXWAIT; k++) begin
            cycle();
            if (!s_drv && !dec_busy) break;
        end
    endtask

    task automatic send_packet(input int lw, input int la);
        pk_armed   = 1'b1;
        pk_started = 1'b0;
        thre_tick  = -1;
        fall_tick  = -1;
        for (int i = 0; i < lw; i++) begin
            n_wr   = 1'b1;
            n_data = pat(lw, i);
            if (i < la) push_exp(pat(lw, i));
            cycle();
            if (i == 1) begin
                check(s_drv == 1'b1 && s_txd == 1'b1, "R7", "enable leads start bit",
                      {s_drv, s_txd}, 3);
            end
        end
        if (lw == 1) begin
            cycle();
            check(s_drv == 1'b1 && s_txd == 1'b1, "R7", "enable leads start bit",
                  {s_drv, s_txd}, 3);
        end
        for (int k = 0; k < MAXWAIT && fall_tick < 0; k++) cycle();
        check(fall_tick == 10 * la, "R7", "release tick count", fall_tick, 10 * la);
        check(thre_tick == 10 * (la - 1), "R4", "holding-empty tick count",
              thre_tick, 10 * (la - 1));
        check(exp_rd == exp_wr, "R3", "all bytes delivered", exp_rd, exp_wr);
        pk_armed   = 1'b0;
        pk_started = 1'b0;
        repeat (4) cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) cycle();
        rst = 1'b0;
        cycle();
        check(s_txd == 1'b1, "R1", "reset txd", s_txd, 1);
        check(s_drv == 1'b0, "R1", "reset drv_en", s_drv, 0);
        check(s_st == 8'h60, "R1", "reset status", s_st, 8'h60);
        check(s_irq == 1'b0, "R1", "reset irq", s_irq, 0);
        repeat (3) cycle();

        // sweep every packet length the queue can take
        for (int l = 1; l <= 16; l++) send_packet(l, l);

        // overflow: 18 writes, 17 fit
        send_packet(18, 17);
        check(s_st[1] == 1'b1, "R8", "overflow flag after dropped write", s_st[1], 1);
        n_clr = 1'b1;
        cycle();
        cycle();
        check(s_st[1] == 1'b0, "R9", "clear resets overflow", s_st[1], 0);

        // single holding register mode
        n_fen = 1'b0;
        repeat (3) cycle();
        n_wr = 1'b1; n_data = 8'hA5; push_exp(8'hA5);
        cycle();
        cycle();
        check(s_st[5] == 1'b0, "R5", "holding full after write", s_st[5], 0);
        n_wr = 1'b1; n_data = 8'h3C; push_exp(8'h3C);
        cycle();
        check(s_st[5] == 1'b1, "R5", "holding empty after move", s_st[5], 1);
        check(s_irq == 1'b1, "R10", "irq pulse single mode", s_irq, 1);
        n_wr = 1'b1; n_data = 8'hFF;
        cycle();
        check(s_irq == 1'b0, "R10", "irq lasts one cycle", s_irq, 0);
        check(s_st[5] == 1'b0, "R5", "second byte waiting", s_st[5], 0);
        cycle();
        check(s_st[1] == 1'b1, "R5", "write to full holding register flagged", s_st[1], 1);
        wait_release();
        check(exp_rd == exp_wr, "R5", "dropped byte not sent", exp_rd, exp_wr);
        n_clr = 1'b1;
        cycle();
        cycle();

        // flush by fifo_clr with a write in the same cycle
        n_fen = 1'b1;
        repeat (3) cycle();
        for (int i = 0; i < 3; i++) begin
            n_wr = 1'b1; n_data = pat(40, i);
            if (i == 0) push_exp(pat(40, i));
            cycle();
        end
        n_clr = 1'b1; n_wr = 1'b1; n_data = 8'h81;
        cycle();
        cycle();
        check(s_st[5] == 1'b1, "R9", "queue empty after clear", s_st[5], 1);
        check(s_st[6] == 1'b0 && s_drv == 1'b1, "R9", "current character continues",
              {s_st[6], s_drv}, 1);
        wait_release();
        check(exp_rd == exp_wr, "R9", "flushed and same-cycle bytes not sent", exp_rd, exp_wr);

        // flush by mode change
        repeat (3) cycle();
        for (int i = 0; i < 3; i++) begin
            n_wr = 1'b1; n_data = pat(50, i);
            if (i == 0) push_exp(pat(50, i));
            cycle();
        end
        n_fen = 1'b0;
        cycle();
        cycle();
        check(s_st[5] == 1'b1, "R11", "mode change empties queue", s_st[5], 1);
        wait_release();
        check(exp_rd == exp_wr, "R11", "flushed bytes not sent", exp_rd, exp_wr);
        check(s_st == 8'h60 && s_txd == 1'b1, "R6", "idle status after drain", s_st, 8'h60);
        n_fen = 1'b1;
        repeat (3) cycle();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule